// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt Entry

This block is a countdown timer of up to 32 bits with a clock prescaler and a small interrupt entry. Software loads a start value, a divide code and an interrupt entry through a simple register port. The entry holds a vector, a mask flag and a mode flag. The current count steps down by one on each divided tick. When the count reaches zero, the block raises an interrupt request that carries the programmed vector, unless the entry is masked. After that it either stops (single-shot mode) or reloads the start value and runs again (repeating mode).

The request leaves the block on a valid/ready channel. `irq_valid` rises when the timer expires. It stays high, and `irq_vector` stays constant, until the receiver asserts `irq_ready` in a cycle where `irq_valid` is high. The receiver may hold `irq_ready` low for as long as it likes, and the timer keeps counting meanwhile. An expiry that arrives while a request is still waiting and not being accepted is dropped. If an expiry arrives in the same cycle as an acceptance, it loads a new request. The read-only pending flag in the entry register mirrors `irq_valid`. What happens to a request after it is accepted is outside this block.

Top module: `tick_timer`

## Requirements
- R1: After reset, the start value and the current count read 0, the divide code reads 0, the interrupt entry reads 0x0001_0000 (masked, single-shot, vector 0), and `irq_valid` is low.
- R2: Register port addresses: 0 is the start value (read/write), 1 is the current count (read-only), 2 is the divide code, and 3 is the interrupt entry. In the interrupt entry, bits 7:0 are the vector, bit 16 is the mask (1 = masked), bit 17 is repeating mode (1 = repeating), and bit 12 is the pending flag. Unused bits read 0. A read returns data in the same cycle as the address.
- R3: The divide code uses bits 3, 1 and 0, and bit 2 is ignored and reads 0. The codes give these divisors: 0000 gives 2, 0001 gives 4, 0010 gives 8, 0011 gives 16, 1000 gives 32, 1001 gives 64, 1010 gives 128, and 1011 gives 1. Writing the divide code restarts the prescaler.
- R4: Writing a nonzero start value N loads the current count with N in the cycle after the write and restarts the prescaler. With divisor D, the count then reads N-k once k·D clock edges have passed since the write edge. This holds up to the largest start value, 0xFFFF_FFFF.
- R5: When the count steps from 1 to 0 and the entry is unmasked, `irq_valid` is high in the same cycle in which the count first reads 0, and `irq_vector` is the programmed vector.
- R6: In single-shot mode the count stays at 0 after expiry and no further request is raised.
- R7: In repeating mode the count reloads the start value on the divided tick after it reaches zero. A request is therefore raised every (N+1)·D cycles.
- R8: A masked expiry raises no request, but counting and reloading continue unchanged.
- R9: Writing a start value of 0 stops the timer. The count reads 0 and no request follows.
- R10: While `irq_valid` is high and `irq_ready` is low, `irq_valid` and `irq_vector` hold, and the pending flag reads 1. An expiry during that time is dropped. An acceptance clears `irq_valid` and the pending flag on the next edge.
- R11: Writes to the current-count address have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_valid | output | 1 | Interrupt request valid |
| irq_ready | input | 1 | Interrupt request accepted by receiver |
| irq_vector | output | 8 | Vector carried by the request |

## Verification
A wrong prescaler phase or divisor decode makes the current count step at the wrong edge. The count is readable every cycle, so the error shows within one divided period after the start-value write. The bench follows the count edge by edge for every divide code, so such an error cannot hide. A wrong zero or reload decision shows up either as a request at the wrong cycle or as a count that does not return to N, within one period. A stuck or dropped pending state shows on `irq_valid` and the pending flag on the edge that follows a stalled or accepted handshake.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // register port addresses
  typedef enum logic [1:0] {
    ADDR_START = 2'd0,
    ADDR_COUNT = 2'd1,
    ADDR_DIV   = 2'd2,
    ADDR_ENTRY = 2'd3
  } reg_addr_e;

  // interrupt entry field positions
  localparam int ENTRY_PEND_BIT   = 12;
  localparam int ENTRY_MASK_BIT   = 16;
  localparam int ENTRY_REPEAT_BIT = 17;

  // prescaler shift width: 3 bits give divisors 1..128
  localparam int SHIFT_W = 3;

  // compact divide code {b3,b1,b0} -> log2 divisor (wraps 7+1 to 0 = /1)
  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [SHIFT_W-1:0] code);
    return code + SHIFT_W'(1);
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tick_timer_pkg::*;
#(
  parameter int SHW = SHIFT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic [SHW-1:0] shift,
  output logic           tick
);
  localparam int PRE_W = (1 << SHW) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (SHW'(i) < shift);
    end
  end

  assign tick = ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else              pre_q <= pre_q + PRE_W'(1);
  end

  // after a restart, the next cycle ticks only for divide-by-one
  assert_restart_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tick == (shift == '0)));

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] start_val,
  input  logic             tick,
  input  logic             repeat_mode,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign count   = cnt_q;
  assign expire  = tick && run_q && (cnt_q == CNT_W'(1)) && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= (load_val != '0);
    end else if (tick && run_q) begin
      if (!at_zero)         cnt_q <= cnt_q - CNT_W'(1);
      else if (repeat_mode) cnt_q <= start_val;
      else                  run_q <= 1'b0;
    end
  end

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_q && !at_zero && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_single_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_q && at_zero && !repeat_mode && !load) |=> (cnt_q == '0 && !run_q));

  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_q && at_zero && repeat_mode && !load) |=> (cnt_q == $past(start_val)));

  assert_zero_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> (!run_q && cnt_q == '0));

endmodule

// File: rtl/tick_irq_stage.sv
module tick_irq_stage #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic             masked,
  input  logic [VEC_W-1:0] vector_in,
  input  logic             irq_ready,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  logic             valid_q;
  logic [VEC_W-1:0] vec_q;
  logic             slot_free;

  assign slot_free  = !valid_q || irq_ready;
  assign irq_valid  = valid_q;
  assign irq_vector = vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
    end else if (expire && !masked && slot_free) begin
      valid_q <= 1'b1;
      vec_q   <= vector_in;
    end else if (irq_ready) begin
      valid_q <= 1'b0;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !irq_ready) |=> (valid_q && $stable(vec_q)));

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && masked && !valid_q) |=> !valid_q);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [VEC_W-1:0] irq_vector
);
  logic [CNT_W-1:0]   start_q;
  logic [SHIFT_W-1:0] div_q;
  logic [VEC_W-1:0]   vec_q;
  logic               mask_q;
  logic               rep_q;

  logic               wr_start, wr_div, wr_entry;
  logic               tick, expire;
  logic [CNT_W-1:0]   count;

  assign wr_start = reg_wr_en && (reg_addr == ADDR_START);
  assign wr_div   = reg_wr_en && (reg_addr == ADDR_DIV);
  assign wr_entry = reg_wr_en && (reg_addr == ADDR_ENTRY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      div_q   <= '0;
      vec_q   <= '0;
      mask_q  <= 1'b1;
      rep_q   <= 1'b0;
    end else begin
      if (wr_start) start_q <= reg_wdata[CNT_W-1:0];
      if (wr_div)   div_q   <= {reg_wdata[3], reg_wdata[1:0]};
      if (wr_entry) begin
        vec_q  <= reg_wdata[VEC_W-1:0];
        mask_q <= reg_wdata[ENTRY_MASK_BIT];
        rep_q  <= reg_wdata[ENTRY_REPEAT_BIT];
      end
    end
  end

  tick_prescaler #(.SHW(SHIFT_W)) i_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_start || wr_div),
    .shift   (code_to_shift(div_q)),
    .tick    (tick)
  );

  tick_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (wr_start),
    .load_val    (reg_wdata[CNT_W-1:0]),
    .start_val   (start_q),
    .tick        (tick),
    .repeat_mode (rep_q),
    .count       (count),
    .expire      (expire)
  );

  tick_irq_stage #(.VEC_W(VEC_W)) i_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (expire),
    .masked     (mask_q),
    .vector_in  (vec_q),
    .irq_ready  (irq_ready),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_START: reg_rdata[CNT_W-1:0] = start_q;
      ADDR_COUNT: reg_rdata[CNT_W-1:0] = count;
      ADDR_DIV:   reg_rdata[3:0] = {div_q[2], 1'b0, div_q[1:0]};
      default: begin
        reg_rdata[VEC_W-1:0]        = vec_q;
        reg_rdata[ENTRY_PEND_BIT]   = irq_valid;
        reg_rdata[ENTRY_MASK_BIT]   = mask_q;
        reg_rdata[ENTRY_REPEAT_BIT] = rep_q;
      end
    endcase
  end

  // a write to the count address alone never moves the count by more than one step
  assert_count_readonly_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == ADDR_COUNT) |=>
      (count == $past(count) || count == $past(count) - CNT_W'(1) || count == start_q));

endmodule

// File: tb/test_tick_timer.sv
`timescale 1ns/100ps
module test_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_valid;
  logic        irq_ready = 1'b1;
  logic [7:0]  irq_vector;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tick_timer i_tick_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_vector(irq_vector)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  function automatic int divisor(input logic [3:0] code);
    case ({code[3], 1'b0, code[1:0]})
      4'b0000: return 2;
      4'b0001: return 4;
      4'b0010: return 8;
      4'b0011: return 16;
      4'b1000: return 32;
      4'b1001: return 64;
      4'b1010: return 128;
      default: return 1;
    endcase
  endfunction

  // start a run and follow count and requests edge by edge (irq_ready held high)
  task automatic run(input logic [3:0] code, input int n, input bit rep, input bit msk,
                     input logic [7:0] vec, input int cycles, input string req_cnt,
                     input string req_irq);
    int d;
    logic [31:0] v;
    logic [31:0] bad_v, bad_e, bad_iv, bad_ie;
    bit cnt_ok, irq_ok;
    d = divisor(code);
    cnt_ok = 1'b1; irq_ok = 1'b1;
    bad_v = 0; bad_e = 0; bad_iv = 0; bad_ie = 0;
    wr(2'd2, {28'd0, code});
    wr(2'd3, (32'(rep) << 17) | (32'(msk) << 16) | 32'(vec));
    wr(2'd0, 32'(n));
    for (int c = 1; c <= cycles; c++) begin
      int t;
      logic [31:0] e;
      bit ev;
      @(posedge clk); #1;
      rd(2'd1, v);
      t = c / d;
      if (rep) e = 32'(n - (t % (n + 1)));
      else     e = (t >= n) ? 32'd0 : 32'(n - t);
      ev = !msk && (c % d == 0) && (rep ? (t % (n + 1) == n) : (t == n));
      if (cnt_ok && v !== e) begin cnt_ok = 1'b0; bad_v = v; bad_e = e; end
      if (irq_ok && (irq_valid !== ev || (ev && irq_vector !== vec))) begin
        irq_ok = 1'b0;
        bad_iv = {23'd0, irq_valid, irq_vector};
        bad_ie = {23'd0, ev, vec};
      end
    end
    chk(req_cnt, bad_v, bad_e);
    chk(req_irq, bad_iv, bad_ie);
    wr(2'd0, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [3:0] codes [10] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9, 4'hA, 4'hB, 4'h4, 4'hF};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 start", v, 32'd0);
    rd(2'd1, v); chk("R1 count", v, 32'd0);
    rd(2'd2, v); chk("R1 divide", v, 32'd0);
    rd(2'd3, v); chk("R1 entry", v, 32'h0001_0000);
    chk("R1 irq_valid", {31'd0, irq_valid}, 32'd0);

    // R2 / R3 readback of field layout
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); chk("R3 divide bit2 ignored", v, 32'hB);
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk("R2 entry fields", v, 32'h0003_00FF);
    wr(2'd0, 32'h0000_A5A5); rd(2'd0, v); chk("R2 start readback", v, 32'h0000_A5A5);
    wr(2'd0, 32'd0);

    // R3 R4 R5 R6 sweep of divide codes and small counts, single-shot
    for (int i = 0; i < 10; i++) begin
      for (int n = 1; n <= 3; n++) begin
        run(codes[i], n, 1'b0, 1'b0, 8'h20 + 8'(i), (n + 3) * divisor(codes[i]),
            "R4 R3 count trajectory", "R5 R6 single-shot request");
      end
    end

    // R7 repeating mode
    run(4'hB, 3, 1'b1, 1'b0, 8'h41, 3 * 4 + 2, "R7 reload trajectory /1", "R7 repeat requests /1");
    run(4'h1, 3, 1'b1, 1'b0, 8'h42, 3 * 16 + 2, "R7 reload trajectory /4", "R7 repeat requests /4");
    run(4'h9, 2, 1'b1, 1'b0, 8'h43, 3 * 3 * 64 + 2, "R7 reload trajectory /64", "R7 repeat requests /64");

    // R8 masked runs keep counting with no request
    run(4'hB, 2, 1'b1, 1'b1, 8'h50, 12, "R8 masked reload trajectory", "R8 masked no request");
    run(4'h0, 2, 1'b0, 1'b1, 8'h51, 10, "R8 masked single trajectory", "R8 masked single no request");

    // R4 largest start value
    wr(2'd3, 32'h0001_0000);
    wr(2'd2, 32'hB);
    wr(2'd0, 32'hFFFF_FFFF);
    repeat (5) @(posedge clk);
    #1; rd(2'd1, v); chk("R4 max count", v, 32'hFFFF_FFFF - 32'd5);

    // R11 write to count address ignored
    wr(2'd0, 32'd20);
    wr(2'd1, 32'h0000_1234);
    rd(2'd1, v); chk("R11 count write ignored", v, 32'd18);
    wr(2'd0, 32'd0);

    // R9 start value zero stops the timer
    begin
      bit seen = 1'b0;
      wr(2'd3, 32'h0000_0033);
      wr(2'd0, 32'd10);
      repeat (3) @(posedge clk);
      wr(2'd0, 32'd0);
      rd(2'd1, v); chk("R9 count zero after stop", v, 32'd0);
      for (int c = 0; c < 20; c++) begin
        @(posedge clk); #1;
        if (irq_valid) seen = 1'b1;
      end
      chk("R9 no request after stop", {31'd0, seen}, 32'd0);
    end

    // R10 back-pressure hold and pending flag
    begin
      bit held = 1'b1;
      @(negedge clk); irq_ready = 1'b0;
      wr(2'd3, 32'h0000_0055);
      wr(2'd0, 32'd2);
      repeat (2) @(posedge clk);
      #1; chk("R5 R10 request raised", {23'd0, irq_valid, irq_vector}, {23'd0, 1'b1, 8'h55});
      for (int c = 0; c < 5; c++) begin
        @(posedge clk); #1;
        if (!irq_valid || irq_vector !== 8'h55) held = 1'b0;
      end
      chk("R10 valid and vector held", {31'd0, held}, 32'd1);
      rd(2'd3, v); chk("R10 pending flag set", {31'd0, v[12]}, 32'd1);
      @(negedge clk); irq_ready = 1'b1;
      @(negedge clk); irq_ready = 1'b0;
      chk("R10 accepted clears valid", {31'd0, irq_valid}, 32'd0);
      rd(2'd3, v); chk("R10 pending flag clear", {31'd0, v[12]}, 32'd0);
    end

    // R10 expiry while pending is dropped
    begin
      bit kept = 1'b1;
      bit found = 1'b0;
      wr(2'd3, 32'h0002_0011);
      wr(2'd0, 32'd1);
      @(posedge clk); #1;
      chk("R10 first repeat request", {23'd0, irq_valid, irq_vector}, {23'd0, 1'b1, 8'h11});
      wr(2'd3, 32'h0002_0022);
      for (int c = 0; c < 6; c++) begin
        @(posedge clk); #1;
        if (!irq_valid || irq_vector !== 8'h11) kept = 1'b0;
      end
      chk("R10 later expiry dropped", {31'd0, kept}, 32'd1);
      @(negedge clk); irq_ready = 1'b1;
      for (int c = 0; c < 6; c++) begin
        @(posedge clk); #1;
        if (irq_valid && irq_vector == 8'h22) found = 1'b1;
      end
      chk("R10 new request after accept", {31'd0, found}, 32'd1);
      wr(2'd0, 32'd0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule